// File: doc/BRIEF.md
# Push-Button Gesture Classifier

This block classifies one push-button gesture each time it is armed. It samples a debounced, active-high button level and, after a start strobe, reports exactly one of four outcomes: no click, single click, double click or hold. The result sits on a two-bit code, and a one-clock done pulse marks it. All timing runs against a free-running tick counter. By default the tick is the system clock divided by 1024, which gives 46.875 kHz for a 48 MHz clock.

The caller supplies a hold time in milliseconds when it arms the block. A zero value selects a default. Window lengths in ticks are (48000 × ms) >> 10, kept modulo the tick-counter width. A window ends on the exact clock where the wrapping tick counter equals the arm-time value plus the window length. A single timer target serves the whole gesture. It starts as the hold window and is rearmed as a double-click window at the first release. A hold-only mode, sampled at the start strobe, skips the double-click phase.

Top module: `btn_gesture`

## Requirements
- R1: While reset is asserted, and after it, done is low and result is 00 until the first gesture is reported.
- R2: A start strobe seen while idle with the button released reports result 00 (no click), with done high in the cycle after the strobe edge.
- R3: Result codes are 01 single, 10 double, 11 hold and 00 no click. done is high for one clock per result, and result keeps its value until the next done.
- R4: If the button stays pressed from the start strobe until the hold window of (48000 × hold_ms) >> 10 ticks has elapsed, result 11 is reported. The window is accurate to one tick.
- R5: A hold_ms of zero selects DEFAULT_HOLD_MS for the hold window.
- R6: After the first release, if no new press arrives within (48000 × DCLICK_MS) >> 10 ticks counted from the release, result 01 is reported at the end of that window.
- R7: A press during the double-click window reports result 10, with done high in the cycle after the press is sampled.
- R8: When hold_only is high at the start strobe, a release before the hold window reports result 01 in the cycle after the release is sampled, with no double-click phase.
- R9: A start strobe arriving while a gesture is being evaluated is ignored.
- R10: The tick counter is TICK_W bits wide and wraps. A window expires on equality with the arm value plus the window length modulo 2^TICK_W, so a window longer than the counter range is shortened to its remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_level | input | 1 | Debounced button level, 1 = pressed |
| start | input | 1 | Arms evaluation of one gesture |
| hold_only | input | 1 | Sampled at start; 1 disables the double-click phase |
| hold_ms | input | MS_W | Hold time in ms, sampled at start; 0 selects the default |
| result | output | 2 | Gesture code, valid from done onwards |
| done | output | 1 | One-clock pulse when a result is reported |

## Verification
The assertions assume that btn_level is already debounced and synchronous to clk. They also assume that hold_ms and hold_only matter only in the cycle of an accepted start strobe, so the checks only relate decisions to the button value sampled one clock earlier. The stimulus changes every input only at falling clock edges. It holds each button level for many cycles and changes hold_ms only while the block is idle. A scaled-down prescaler and tick width keep the windows short enough that a window, and a counter wrap, each fit in a few hundred cycles. The timing checks accept a spread of one tick period, because the phase of the free-running prescaler at the strobe is not controlled.

// File: rtl/btn_gesture_pkg.sv
package btn_gesture_pkg;
  typedef enum logic [1:0] {
    RES_NONE   = 2'b00,
    RES_SINGLE = 2'b01,
    RES_DOUBLE = 2'b10,
    RES_HOLD   = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_PRESSED  = 2'b01,
    ST_RELEASED = 2'b10
  } st_e;
endpackage

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
  parameter int DIV_LOG2 = 10,
  parameter int TICK_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TICK_W-1:0] tick_cnt
);
  logic              tick_en;
  logic [TICK_W-1:0] cnt_q, cnt_d;

  generate
    if (DIV_LOG2 > 0) begin : g_pre
      logic [DIV_LOG2-1:0] pre_q, pre_d;
      always_comb begin
        pre_d   = pre_q + 1'b1;
        tick_en = &pre_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign tick_en = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_cnt = cnt_q;

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + TICK_W'(1))); // R10
endmodule

// File: rtl/btn_window_calc.sv
module btn_window_calc #(
  parameter int MS_W            = 16,
  parameter int TICK_W          = 16,
  parameter int RATE_K          = 48000,
  parameter int WIN_SHIFT       = 10,
  parameter int DEFAULT_HOLD_MS = 1000,
  parameter int DCLICK_MS       = 500
) (
  input  logic [MS_W-1:0]   hold_ms,
  output logic [TICK_W-1:0] hold_win,
  output logic [TICK_W-1:0] dbl_win
);
  localparam int PROD_W = MS_W + 17;
  localparam longint unsigned DBL_TICKS =
    (longint'(RATE_K) * longint'(DCLICK_MS)) >> WIN_SHIFT;

  logic [MS_W-1:0]   eff_ms;
  logic [PROD_W-1:0] prod;

  always_comb begin
    eff_ms   = (hold_ms == '0) ? MS_W'(DEFAULT_HOLD_MS) : hold_ms;
    prod     = PROD_W'(RATE_K) * PROD_W'(eff_ms);
    hold_win = TICK_W'(prod >> WIN_SHIFT);
    dbl_win  = TICK_W'(DBL_TICKS);
  end
endmodule

// File: rtl/btn_gesture_fsm.sv
module btn_gesture_fsm
  import btn_gesture_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn,
  input  logic              start,
  input  logic              hold_only,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [TICK_W-1:0] hold_win,
  input  logic [TICK_W-1:0] dbl_win,
  output logic [1:0]        result,
  output logic              done
);
  st_e               st_q, st_d;
  logic [TICK_W-1:0] tgt_q, tgt_d;
  logic              mode_q, mode_d;
  res_e              res_q, res_d;
  logic              done_q, done_d;
  logic              expired;

  always_comb begin
    expired = (tick_cnt == tgt_q);
    st_d    = st_q;
    tgt_d   = tgt_q;
    mode_d  = mode_q;
    res_d   = res_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!btn) begin
            done_d = 1'b1;
            res_d  = RES_NONE;
          end else begin
            st_d   = ST_PRESSED;
            tgt_d  = tick_cnt + hold_win;
            mode_d = hold_only;
          end
        end
      end
      ST_PRESSED: begin
        if (!btn) begin
          if (mode_q) begin
            done_d = 1'b1;
            res_d  = RES_SINGLE;
            st_d   = ST_IDLE;
          end else begin
            st_d  = ST_RELEASED;
            tgt_d = tick_cnt + dbl_win;
          end
        end else if (expired) begin
          done_d = 1'b1;
          res_d  = RES_HOLD;
          st_d   = ST_IDLE;
        end
      end
      ST_RELEASED: begin
        if (btn) begin
          done_d = 1'b1;
          res_d  = RES_DOUBLE;
          st_d   = ST_IDLE;
        end else if (expired) begin
          done_d = 1'b1;
          res_d  = RES_SINGLE;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= '0;
      mode_q <= 1'b0;
      res_q  <= RES_NONE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tgt_q  <= tgt_d;
      mode_q <= mode_d;
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  AST_NOCLICK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && !btn) |=> (done_q && res_q == RES_NONE)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(res_q)); // R3
  AST_HOLD_PRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && res_q == RES_HOLD) |-> $past(btn)); // R4
  AST_SINGLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && res_q == RES_SINGLE) |-> !$past(btn)); // R6
  AST_DOUBLE_PRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && res_q == RES_DOUBLE) |-> ($past(btn) && !$past(mode_q))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRESSED && btn && start && !expired) |=> (st_q == ST_PRESSED)); // R9
endmodule

// File: rtl/btn_gesture.sv
module btn_gesture #(
  parameter int DIV_LOG2        = 10,
  parameter int TICK_W          = 16,
  parameter int MS_W            = 16,
  parameter int DEFAULT_HOLD_MS = 1000,
  parameter int DCLICK_MS       = 500
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            btn_level,
  input  logic            start,
  input  logic            hold_only,
  input  logic [MS_W-1:0] hold_ms,
  output logic [1:0]      result,
  output logic            done
);
  logic              rst_s1_q, rst_s2_q;
  logic [TICK_W-1:0] tick_cnt;
  logic [TICK_W-1:0] hold_win, dbl_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  btn_tick_gen #(.DIV_LOG2(DIV_LOG2), .TICK_W(TICK_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .tick_cnt (tick_cnt)
  );

  btn_window_calc #(
    .MS_W(MS_W), .TICK_W(TICK_W), .RATE_K(48000), .WIN_SHIFT(10),
    .DEFAULT_HOLD_MS(DEFAULT_HOLD_MS), .DCLICK_MS(DCLICK_MS)
  ) u_win (
    .hold_ms  (hold_ms),
    .hold_win (hold_win),
    .dbl_win  (dbl_win)
  );

  btn_gesture_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .btn       (btn_level),
    .start     (start),
    .hold_only (hold_only),
    .tick_cnt  (tick_cnt),
    .hold_win  (hold_win),
    .dbl_win   (dbl_win),
    .result    (result),
    .done      (done)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $rose(rst_s2_q) |-> (!done && result == 2'b00)); // R1
endmodule

// File: tb/btn_gesture_bench.sv
module btn_gesture_bench;
  localparam int DIV_LOG2 = 2;
  localparam int TICK_W   = 8;
  localparam int MS_W     = 16;
  localparam int DEF_MS   = 4;
  localparam int DCL_MS   = 2;
  localparam int P        = 1 << DIV_LOG2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            btn_level, start, hold_only;
  logic [MS_W-1:0] hold_ms;
  logic [1:0]      result;
  logic            done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  btn_gesture #(
    .DIV_LOG2(DIV_LOG2), .TICK_W(TICK_W), .MS_W(MS_W),
    .DEFAULT_HOLD_MS(DEF_MS), .DCLICK_MS(DCL_MS)
  ) u_btn_gesture (
    .clk(clk), .rst_n(rst_n), .btn_level(btn_level), .start(start),
    .hold_only(hold_only), .hold_ms(hold_ms), .result(result), .done(done)
  );

  function automatic int win_ticks(int ms);
    return ((48000 * ms) >> 10) % (1 << TICK_W);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, string what, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // counts negedges until done is seen; a start pulse may be injected at inj
  task automatic wait_done(int lim, int inj, output int n);
    n = 0;
    while (!done && n < lim) begin
      @(negedge clk);
      n++;
      if (n == inj)     start = 1'b1;
      if (n == inj + 1) start = 1'b0;
    end
  endtask

  task automatic quiet(int cyc, output int seen);
    seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (done) seen++;
    end
  endtask

  task automatic t_hold();
    int n, w;
    w = win_ticks(1);
    @(negedge clk) begin btn_level = 1'b1; hold_ms = 16'd1; end
    pulse_start();
    wait_done(2000, 40, n);
    chk_range("R4", "hold delay", n, (w - 1) * P, w * P + 2);
    chk(result == 2'b11, "R4", "hold code", result, 3);
    @(negedge clk) btn_level = 1'b0;
    chk(!done, "R3", "done one clock", done, 0);
    repeat (5) @(negedge clk);
    chk(result == 2'b11, "R3", "result held", result, 3);
  endtask

  task automatic t_noclick();
    @(negedge clk) btn_level = 1'b0;
    pulse_start();
    chk(done, "R2", "no-click done at once", done, 1);
    chk(result == 2'b00, "R2", "no-click code", result, 0);
    @(negedge clk);
  endtask

  task automatic t_default();
    int n, w;
    w = win_ticks(DEF_MS);
    @(negedge clk) begin btn_level = 1'b1; hold_ms = 16'd0; end
    pulse_start();
    wait_done(5000, 0, n);
    chk_range("R5", "default hold delay", n, (w - 1) * P, w * P + 2);
    chk(result == 2'b11, "R5", "default hold code", result, 3);
    @(negedge clk) btn_level = 1'b0;
  endtask

  task automatic t_wrap();
    int n, w;
    w = win_ticks(6);
    @(negedge clk) begin btn_level = 1'b1; hold_ms = 16'd6; end
    pulse_start();
    wait_done(5000, 0, n);
    chk_range("R10", "wrapped window delay", n, (w - 1) * P, w * P + 2);
    chk(result == 2'b11, "R10", "wrapped hold code", result, 3);
    @(negedge clk) btn_level = 1'b0;
  endtask

  task automatic t_single();
    int n, seen, d;
    d = win_ticks(DCL_MS);
    @(negedge clk) begin btn_level = 1'b1; hold_ms = 16'd1; end
    pulse_start();
    quiet(20, seen);
    chk(seen == 0, "R6", "no early result", seen, 0);
    btn_level = 1'b0;
    @(negedge clk);
    wait_done(5000, 10, n);
    chk_range("R9", "start during window ignored", n, 12, 100000);
    chk_range("R6", "single delay", n, (d - 1) * P, d * P + 2);
    chk(result == 2'b01, "R6", "single code", result, 1);
  endtask

  task automatic t_double();
    int seen;
    @(negedge clk) begin btn_level = 1'b1; hold_ms = 16'd1; end
    pulse_start();
    quiet(20, seen);
    btn_level = 1'b0;
    quiet(40, seen);
    chk(seen == 0, "R7", "no result between presses", seen, 0);
    btn_level = 1'b1;
    @(negedge clk);
    chk(done, "R7", "double done", done, 1);
    chk(result == 2'b10, "R7", "double code", result, 2);
    @(negedge clk) btn_level = 1'b0;
  endtask

  task automatic t_hold_only();
    int seen;
    @(negedge clk) begin btn_level = 1'b1; hold_only = 1'b1; hold_ms = 16'd1; end
    pulse_start();
    hold_only = 1'b0;
    quiet(20, seen);
    btn_level = 1'b0;
    @(negedge clk);
    chk(done, "R8", "hold-only release done", done, 1);
    chk(result == 2'b01, "R8", "hold-only single code", result, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; btn_level = 1'b0; start = 1'b0; hold_only = 1'b0; hold_ms = '0;
    repeat (4) @(negedge clk);
    chk(!done, "R1", "done in reset", done, 0);
    chk(result == 2'b00, "R1", "result in reset", result, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && result == 2'b00, "R1", "after reset", {done, result}, 0);
    t_hold();
    t_noclick();
    t_default();
    t_wrap();
    t_single();
    t_double();
    t_hold_only();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule